// File: doc/BRIEF.md
# Nonvolatile Register Bank with Timed Commit

This block holds a small bank of general-purpose setting registers that stand in for nonvolatile cells. A serial command decoder upstream hands it finished requests. A request is either a host value for a chosen register or a copy of the present wiper position into a chosen register. The bank does not write at once. It keeps one pending value and commits it only after the chip select is released. The commit runs as a timed internal write cycle, and a busy flag stays high for the whole cycle so that the host can poll it.

Any register can be read at any time through a combinational read port. Register 0 is also driven out on its own so that the wiper logic can load it at power-up. The write-protect pin blocks only writes into this bank; it has no effect on the wiper itself. The storage is plain flops, and the cell write delay is a cycle counter set by a parameter.

Top module: `nvreg_bank`

## Requirements
- R1: After reset all registers read 0, the recall output is 0 and the busy flag is low.
- R2: A host write or wiper transfer is accepted only while chip select (cs_ni) is low, write protect (wp_ni) is high and busy is low. Accepting it changes no register until chip select rises.
- R3: When chip select goes from low to high with a pending request, busy rises on the next clock and stays high for exactly WR_CYCLES clocks.
- R4: The selected register takes the pending value on the clock where busy falls, and no other register changes.
- R5: A wiper transfer stores the value of wiper_i as sampled on the clock the request was accepted.
- R6: While wp_ni is low, host writes and wiper transfers are refused. No commit follows and no register changes.
- R7: While busy is high, new write and transfer requests are ignored.
- R8: A chip-select release with nothing pending (an aborted or non-matching sequence) starts no write cycle.
- R9: rd_data_o always shows the register chosen by rd_sel_i. During a write cycle it still shows the old value.
- R10: recall_o always equals register 0.
- R11: If a host write and a wiper transfer are requested on the same clock, the host write wins.
- R12: A request that arrives while chip select is high is discarded. A later release commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low; a rising edge triggers the commit |
| wp_ni | input | 1 | Write protect, active low; blocks bank writes |
| wr_req_i | input | 1 | One-clock pulse: a complete host write sequence has been received |
| xfer_req_i | input | 1 | One-clock pulse: a complete wiper-to-register transfer has been received |
| sel_i | input | SEL_W | Target register pointer for the request |
| wr_data_i | input | DATA_W | Host data for a write |
| wiper_i | input | DATA_W | Present wiper position |
| rd_sel_i | input | SEL_W | Read pointer |
| rd_data_o | output | DATA_W | Content of the register chosen by rd_sel_i |
| recall_o | output | DATA_W | Content of register 0, used for the power-up wiper load |
| busy_o | output | 1 | Write-in-progress flag |

## Verification
The bench uses the default four 6-bit registers with WR_CYCLES set to 5. With this setting every data value can be committed into every register, by both the host path and the transfer path, in a few thousand clocks. The short cycle also makes the exact busy length measurable, and it leaves room to inject requests in the middle of a write cycle. The refusal cases (protect low, busy, release with nothing pending, request with chip select high) are each followed by a full readback of the bank.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_HOST  = 2'd1,
    SRC_WIPER = 2'd2
  } nv_src_e;

  function automatic nv_src_e pick_src(input logic wr, input logic xfer);
    if (wr)        return SRC_HOST;
    else if (xfer) return SRC_WIPER;
    else           return SRC_NONE;
  endfunction
endpackage

// File: rtl/nvb_arm.sv
module nvb_arm #(
  parameter int unsigned DATA_W = 6,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wp_ni,
  input  logic              busy_i,
  input  logic              wr_req_i,
  input  logic              xfer_req_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] wiper_i,
  output logic              pend_o,
  output logic              cs_rise_o,
  output logic [SEL_W-1:0]  pend_sel_o,
  output logic [DATA_W-1:0] pend_data_o
);
  import nvb_pkg::*;

  logic    cs_q;
  logic    accept;
  nv_src_e src;

  assign src       = pick_src(wr_req_i, xfer_req_i);
  assign cs_rise_o = cs_ni & ~cs_q;
  assign accept    = ~cs_ni & wp_ni & ~busy_i & (src != SRC_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q        <= 1'b1;
      pend_o      <= 1'b0;
      pend_sel_o  <= '0;
      pend_data_o <= '0;
    end else begin
      cs_q <= cs_ni;
      if (cs_rise_o) begin
        pend_o <= 1'b0;
      end else if (accept) begin
        pend_o      <= 1'b1;
        pend_sel_o  <= sel_i;
        pend_data_o <= (src == SRC_HOST) ? wr_data_i : wiper_i;
      end
    end
  end
endmodule

// File: rtl/nvb_timer.sv
module nvb_timer #(
  parameter int unsigned WR_CYCLES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = (WR_CYCLES < 2) ? 1 : $clog2(WR_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end else if (done_o) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nvb_store.sv
module nvb_store #(
  parameter int unsigned DATA_W   = 6,
  parameter int unsigned NUM_REGS = 4,
  localparam int unsigned SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SEL_W-1:0]           wsel_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [SEL_W-1:0]           rsel_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [DATA_W-1:0]          reg0_o,
  output logic [DATA_W*NUM_REGS-1:0] flat_o
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem[i] <= '0;
      else if (we_i && (wsel_i == SEL_W'(i)))    mem[i] <= wdata_i;
    end
    assign flat_o[i*DATA_W +: DATA_W] = mem[i];
  end

  assign rdata_o = mem[rsel_i];
  assign reg0_o  = mem[0];
endmodule

// File: rtl/nvreg_bank.sv
module nvreg_bank #(
  parameter int unsigned DATA_W    = 6,
  parameter int unsigned NUM_REGS  = 4,
  parameter int unsigned WR_CYCLES = 5,
  localparam int unsigned SEL_W    = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wp_ni,
  input  logic              wr_req_i,
  input  logic              xfer_req_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [DATA_W-1:0] wiper_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] recall_o,
  output logic              busy_o
);
  logic                       pend;
  logic                       cs_rise;
  logic                       done;
  logic [SEL_W-1:0]           pend_sel;
  logic [DATA_W-1:0]          pend_data;
  logic [DATA_W*NUM_REGS-1:0] mem_flat;

  nvb_arm #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_arm (
    .clk_i, .rst_ni, .cs_ni, .wp_ni,
    .busy_i(busy_o), .wr_req_i, .xfer_req_i, .sel_i, .wr_data_i, .wiper_i,
    .pend_o(pend), .cs_rise_o(cs_rise), .pend_sel_o(pend_sel), .pend_data_o(pend_data)
  );

  nvb_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .start_i(cs_rise & pend), .busy_o(busy_o), .done_o(done)
  );

  nvb_store #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk_i, .rst_ni,
    .we_i(done), .wsel_i(pend_sel), .wdata_i(pend_data),
    .rsel_i(rd_sel_i), .rdata_o(rd_data_o), .reg0_o(recall_o), .flat_o(mem_flat)
  );
endmodule

// File: rtl/nvreg_bank_chk.sv
module nvreg_bank_chk #(
  parameter int unsigned MEM_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wp_ni,
  input logic             busy_o,
  input logic             pend_i,
  input logic             cs_rise_i,
  input logic [MEM_W-1:0] mem_i
);
  // R3
  a_r3_start_after_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && pend_i) |=> busy_o);
  // R8
  a_r8_release_unarmed_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && !pend_i && !busy_o) |=> !busy_o);
  // R6
  a_r6_protect_never_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_ni && !pend_i) |=> !pend_i);
  // R7
  a_r7_busy_never_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !pend_i) |=> !pend_i);
  // R4
  a_r4_store_moves_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_i) |-> $fell(busy_o));
endmodule

bind nvreg_bank nvreg_bank_chk #(.MEM_W(DATA_W*NUM_REGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wp_ni(wp_ni), .busy_o(busy_o),
  .pend_i(pend), .cs_rise_i(cs_rise), .mem_i(mem_flat)
);

// File: tb/nvreg_bank_bench.sv
module nvreg_bank_bench;
  localparam int WR = 5;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1;
  logic       wp_ni = 1'b1;
  logic       wr_req_i = 1'b0;
  logic       xfer_req_i = 1'b0;
  logic [1:0] sel_i = '0;
  logic [5:0] wr_data_i = '0;
  logic [5:0] wiper_i = '0;
  logic [1:0] rd_sel_i = '0;
  logic [5:0] rd_data_o, recall_o;
  logic       busy_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [5:0] model [4];

  always #2.5 clk_i = ~clk_i;

  nvreg_bank #(.DATA_W(6), .NUM_REGS(4), .WR_CYCLES(WR)) u_nvreg_bank (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < 4; i++) begin
      rd_sel_i = 2'(i);
      #0.1;
      chk(rd_data_o == model[i], tag, rd_data_o, model[i]);
    end
    chk(recall_o == model[0], "R10 recall", recall_o, model[0]);
  endtask

  // one framed request; returns busy length seen after release
  task automatic frame(input bit wr, input bit xf, input logic [1:0] s,
                       input logic [5:0] d, input logic [5:0] w, output int n);
    @(negedge clk_i) cs_ni = 1'b0;
    @(negedge clk_i) begin
      wr_req_i = wr; xfer_req_i = xf; sel_i = s; wr_data_i = d; wiper_i = w;
    end
    @(negedge clk_i) begin
      wr_req_i = 1'b0; xfer_req_i = 1'b0; wiper_i = ~w; wr_data_i = ~d; cs_ni = 1'b1;
    end
    n = 0;
    repeat (WR + 3) @(negedge clk_i) if (busy_o) n++;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 4; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    chk(busy_o == 1'b0, "R1 busy at reset", busy_o, 0);
    check_bank("R1 reset contents");
    rst_ni = 1'b1;

    // R2 R3 R4 R5: every value into every register, alternating source
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 64; d++) begin
        bit use_x = d[0];
        frame(!use_x, use_x, 2'(s), use_x ? 6'(~d) : 6'(d), use_x ? 6'(d) : 6'(~d), n);
        chk(n == WR, "R3 busy length", n, WR);
        model[s] = 6'(d);
        check_bank(use_x ? "R5 transfer stored" : "R4 write stored");
      end
    end

    // R2 / R9: no change before release, old value during busy
    @(negedge clk_i) cs_ni = 1'b0;
    @(negedge clk_i) begin wr_req_i = 1'b1; sel_i = 2'd1; wr_data_i = 6'd7; end
    @(negedge clk_i) wr_req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check_bank("R2 held until release");
    chk(busy_o == 1'b0, "R2 no busy before release", busy_o, 0);
    cs_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b1, "R3 busy next clock", busy_o, 1);
    rd_sel_i = 2'd1; #0.1;
    chk(rd_data_o == model[1], "R9 old value while busy", rd_data_o, model[1]);
    // R7: request during busy is ignored
    @(negedge clk_i) cs_ni = 1'b0;
    @(negedge clk_i) begin wr_req_i = 1'b1; sel_i = 2'd2; wr_data_i = 6'd21; end
    @(negedge clk_i) begin wr_req_i = 1'b0; cs_ni = 1'b1; end
    repeat (WR + 3) @(negedge clk_i);
    model[1] = 6'd7;
    chk(busy_o == 1'b0, "R7 no second cycle", busy_o, 0);
    check_bank("R7 busy request dropped");

    // R6: write protect
    wp_ni = 1'b0;
    frame(1'b1, 1'b0, 2'd3, 6'd44, 6'd0, n);
    chk(n == 0, "R6 protected write", n, 0);
    frame(1'b0, 1'b1, 2'd0, 6'd0, 6'd55, n);
    chk(n == 0, "R6 protected transfer", n, 0);
    check_bank("R6 bank unchanged");
    wp_ni = 1'b1;

    // R8: abort, release with nothing pending
    frame(1'b0, 1'b0, 2'd2, 6'd9, 6'd9, n);
    chk(n == 0, "R8 unarmed release", n, 0);
    check_bank("R8 bank unchanged");

    // R12: request while deselected
    @(negedge clk_i) begin wr_req_i = 1'b1; sel_i = 2'd0; wr_data_i = 6'd33; end
    @(negedge clk_i) wr_req_i = 1'b0;
    @(negedge clk_i) cs_ni = 1'b0;
    @(negedge clk_i) cs_ni = 1'b1;
    n = 0;
    repeat (WR + 3) @(negedge clk_i) if (busy_o) n++;
    chk(n == 0, "R12 deselected request", n, 0);
    check_bank("R12 bank unchanged");

    // R11: simultaneous requests, host wins
    frame(1'b1, 1'b1, 2'd2, 6'd12, 6'd50, n);
    chk(n == WR, "R11 busy length", n, WR);
    model[2] = 6'd12;
    check_bank("R11 host wins");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule